// File: doc/BRIEF.md
# Voltage Setpoint Ramp Controller

This block steers the output setpoint code of a single buck regulator while that regulator is moving between voltages. The code changes in steps of one, so the output voltage changes gradually. Two setpoint codes are held outside the block: a run code and a standby code. A standby pin chooses which of the two is the target. The block moves its output code toward the selected target by one code at a time. Between steps it waits for a number of 1 µs ticks. That wait is set by a 2-bit speed field, which the block keeps in its own register.

A ramp starts in two ways. One is a write that changes the active setpoint. The other is a toggle of the standby pin. While the output code and the target differ, the block reports that it is busy and masks the regulator's overcurrent flag. In the 7-bit variant, a target code whose top bit is set lies in the coarse range. There each code is worth 50 mV instead of 25 mV, and the dwell between steps is twice as long. The 6-bit variant always uses fine steps.

The controls are level-driven, not a data stream, so no valid/ready handshake appears. A new setpoint is taken on any cycle, and nothing ever back-pressures the source.

Top module: `dvs_ramp_ctrl`

## Requirements
- R1: With `standby` low the target is `run_code`; with `standby` high the target is `stby_code`.
- R2: Speed value 0, 1, 2, 3 gives a dwell of 2, 4, 8, 16 ticks of `tick_us` per fine step. A step happens on the clock edge where the dwell's last tick is seen.
- R3: After reset `vout_code` is 0, `busy` is low and the speed register holds 1 (4-tick dwell). `speed_we` high on a clock edge loads `speed_in`.
- R4: Each step moves `vout_code` by exactly one code toward the target. The code stops at the target without overshoot and never moves while it equals the target.
- R5: With CODE_W = 7 and bit 6 of the selected target set, `coarse_step` is high and each dwell is doubled (4, 8, 16, 32 ticks).
- R6: With CODE_W = 6 there is no coarse range: `coarse_step` stays low and dwells are never doubled.
- R7: `busy` is high in exactly the cycles where `vout_code` differs from the selected target. `oc_mask` equals `busy`, and `oc_flag` is `oc_raw` with `oc_mask` applied.
- R8: A change of the selected target restarts the dwell count. Ticks seen on that edge are discarded, and the ramp continues from the present code toward the new target.
- R9: `vout_code` changes only on an edge where `tick_us` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_us | input | 1 | One-cycle pulse every microsecond |
| standby | input | 1 | Selects the standby setpoint as target when high |
| run_code | input | CODE_W | Run setpoint code |
| stby_code | input | CODE_W | Standby setpoint code |
| speed_we | input | 1 | Loads `speed_in` into the speed register |
| speed_in | input | 2 | New speed value |
| oc_raw | input | 1 | Overcurrent flag from the regulator |
| vout_code | output | CODE_W | Present setpoint code sent to the regulator |
| busy | output | 1 | Ramp in progress |
| oc_mask | output | 1 | Overcurrent mask, high while ramping |
| oc_flag | output | 1 | Overcurrent flag after masking |
| coarse_step | output | 1 | Selected target lies in the 50 mV range |

## Verification
The bench builds two copies side by side from the same stimulus: one with CODE_W = 7 and one with CODE_W = 6. The 6-bit copy sees the low six bits of each setpoint. A target above 63 therefore exercises the coarse-range doubling in one copy, and the same transition shows that the other copy ignores it. Both are compared cycle by cycle against a bench model, and directed first-step timing runs cover each speed value.

// File: rtl/dvs_pkg.sv
package dvs_pkg;
  typedef enum logic [1:0] {
    SPD_2T  = 2'd0,
    SPD_4T  = 2'd1,
    SPD_8T  = 2'd2,
    SPD_16T = 2'd3
  } dvs_speed_e;

  localparam dvs_speed_e SPEED_RESET = SPD_4T;
  localparam int         DWELL_W     = 6;

  // Fine-step dwell in ticks is 2 << speed; the coarse range doubles it.
  function automatic logic [DWELL_W-1:0] dwell_ticks(input dvs_speed_e spd,
                                                     input logic coarse);
    logic [DWELL_W-1:0] base;
    base = DWELL_W'(2) << spd;
    return coarse ? (base << 1) : base;
  endfunction
endpackage

// File: rtl/dvs_target_sel.sv
module dvs_target_sel #(
  parameter int CODE_W = 7
) (
  input  logic              standby,
  input  logic [CODE_W-1:0] run_code,
  input  logic [CODE_W-1:0] stby_code,
  output logic [CODE_W-1:0] tgt_code,
  output logic              coarse
);
  localparam bit HAS_COARSE = (CODE_W >= 7);

  assign tgt_code = standby ? stby_code : run_code;

  generate
    if (HAS_COARSE) begin : g_coarse
      assign coarse = tgt_code[CODE_W-1];
    end else begin : g_fine
      assign coarse = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/dvs_dwell_timer.sv
module dvs_dwell_timer
  import dvs_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               active,
  input  logic               restart,
  input  logic [DWELL_W-1:0] dwell,
  output logic               step
);
  logic [DWELL_W-1:0] cnt_q;
  logic               last_tick;

  assign last_tick = (cnt_q >= dwell - DWELL_W'(1));
  assign step      = active && !restart && tick && last_tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (restart || !active) begin
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= last_tick ? '0 : cnt_q + DWELL_W'(1);
    end
  end
endmodule

// File: rtl/dvs_code_stepper.sv
module dvs_code_stepper #(
  parameter int CODE_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic [CODE_W-1:0] tgt_code,
  output logic [CODE_W-1:0] cur_code
);
  logic [CODE_W-1:0] cur_q;
  logic              go_up;

  assign go_up    = (tgt_code > cur_q);
  assign cur_code = cur_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= '0;
    end else if (step && (tgt_code != cur_q)) begin
      cur_q <= go_up ? cur_q + CODE_W'(1) : cur_q - CODE_W'(1);
    end
  end
endmodule

// File: rtl/dvs_ramp_ctrl.sv
module dvs_ramp_ctrl
  import dvs_pkg::*;
#(
  parameter int CODE_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_us,
  input  logic              standby,
  input  logic [CODE_W-1:0] run_code,
  input  logic [CODE_W-1:0] stby_code,
  input  logic              speed_we,
  input  logic [1:0]        speed_in,
  input  logic              oc_raw,
  output logic [CODE_W-1:0] vout_code,
  output logic              busy,
  output logic              oc_mask,
  output logic              oc_flag,
  output logic              coarse_step
);
  logic [CODE_W-1:0]  tgt_code;
  logic [CODE_W-1:0]  tgt_q;
  logic [CODE_W-1:0]  cur_code;
  logic               coarse;
  logic               restart;
  logic               step;
  logic [DWELL_W-1:0] dwell;
  dvs_speed_e         speed_q;

  dvs_target_sel #(.CODE_W(CODE_W)) u_sel (
    .standby  (standby),
    .run_code (run_code),
    .stby_code(stby_code),
    .tgt_code (tgt_code),
    .coarse   (coarse)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      speed_q <= SPEED_RESET;
      tgt_q   <= '0;
    end else begin
      if (speed_we) speed_q <= dvs_speed_e'(speed_in);
      tgt_q <= tgt_code;
    end
  end

  assign restart = (tgt_code != tgt_q);
  assign dwell   = dwell_ticks(speed_q, coarse);
  assign busy    = (cur_code != tgt_code);

  dvs_dwell_timer u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick_us),
    .active (busy),
    .restart(restart),
    .dwell  (dwell),
    .step   (step)
  );

  dvs_code_stepper #(.CODE_W(CODE_W)) u_step (
    .clk     (clk),
    .rst_n   (rst_n),
    .step    (step),
    .tgt_code(tgt_code),
    .cur_code(cur_code)
  );

  assign vout_code   = cur_code;
  assign oc_mask     = busy;
  assign oc_flag     = oc_raw && !oc_mask;
  assign coarse_step = coarse;
endmodule

// File: rtl/dvs_ramp_ctrl_chk.sv
module dvs_ramp_ctrl_chk #(
  parameter int CODE_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_us,
  input logic [CODE_W-1:0] cur,
  input logic [CODE_W-1:0] tgt,
  input logic              busy,
  input logic              oc_mask,
  input logic              oc_flag
);
  assert_single_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cur == $past(cur)) || (cur == $past(cur) + CODE_W'(1)) ||
             (cur == $past(cur) - CODE_W'(1)));

  assert_toward_target_R4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(cur) <= $past(tgt)) ? (cur >= $past(cur) && cur <= $past(tgt))
                                          : (cur <= $past(cur) && cur >= $past(tgt))));

  assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(cur));

  assert_tick_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_us |=> $stable(cur));

  assert_flag_masked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    oc_flag |-> !oc_mask && !busy);
endmodule

bind dvs_ramp_ctrl dvs_ramp_ctrl_chk #(.CODE_W(CODE_W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .tick_us(tick_us),
  .cur    (vout_code),
  .tgt    (tgt_code),
  .busy   (busy),
  .oc_mask(oc_mask),
  .oc_flag(oc_flag)
);

// File: tb/dvs_ramp_ctrl_bench.sv
`timescale 1ns/1ps
module dvs_ramp_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_us = 1'b0;
  logic       standby = 1'b0;
  logic [6:0] run_code = '0;
  logic [6:0] stby_code = '0;
  logic       speed_we = 1'b0;
  logic [1:0] speed_in = '0;
  logic       oc_raw = 1'b0;
  logic       tick_en = 1'b1;

  logic [6:0] cur7;
  logic [5:0] cur6;
  logic busy7, mask7, flag7, coarse7;
  logic busy6, mask6, flag6, coarse6;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  dvs_ramp_ctrl #(.CODE_W(7)) u_dvs_ramp_ctrl (
    .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .standby(standby),
    .run_code(run_code), .stby_code(stby_code), .speed_we(speed_we),
    .speed_in(speed_in), .oc_raw(oc_raw), .vout_code(cur7), .busy(busy7),
    .oc_mask(mask7), .oc_flag(flag7), .coarse_step(coarse7));

  dvs_ramp_ctrl #(.CODE_W(6)) u_dvs_ramp_ctrl_w6 (
    .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .standby(standby),
    .run_code(run_code[5:0]), .stby_code(stby_code[5:0]), .speed_we(speed_we),
    .speed_in(speed_in), .oc_raw(oc_raw), .vout_code(cur6), .busy(busy6),
    .oc_mask(mask6), .oc_flag(flag6), .coarse_step(coarse6));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Bench model state
  logic [6:0] m7_cur, m7_tq, m6_cur, m6_tq;
  logic [5:0] m7_cnt, m6_cnt;
  logic [1:0] m_spd;

  function automatic logic [6:0] sel_target(input int w);
    logic [6:0] t;
    t = standby ? stby_code : run_code;
    if (w == 6) t[6] = 1'b0;
    return t;
  endfunction

  function automatic logic [5:0] exp_dwell(input logic [1:0] s, input logic hi);
    int d;
    d = 2 << s;
    if (hi) d = d * 2;
    return 6'(d);
  endfunction

  task automatic model_step(input logic [6:0] t, input logic hi,
                            inout logic [6:0] cur, inout logic [5:0] cnt,
                            inout logic [6:0] tq);
    logic [5:0] d;
    d = exp_dwell(m_spd, hi);
    if (t != tq) cnt = 0;
    else if (cur == t) cnt = 0;
    else if (tick_us) begin
      if (cnt >= d - 6'd1) begin
        cur = (cur < t) ? cur + 7'd1 : cur - 7'd1;
        cnt = 0;
      end else cnt = cnt + 6'd1;
    end
    tq = t;
  endtask

  always @(posedge clk) begin
    logic [6:0] t7, t6;
    t7 = sel_target(7);
    t6 = sel_target(6);
    if (!rst_n) begin
      m7_cur = 0; m7_cnt = 0; m7_tq = 0;
      m6_cur = 0; m6_cnt = 0; m6_tq = 0;
      m_spd = 2'd1;
    end else begin
      model_step(t7, t7[6], m7_cur, m7_cnt, m7_tq);
      model_step(t6, 1'b0, m6_cur, m6_cnt, m6_tq);
      if (speed_we) m_spd = speed_in;
    end
    #2;
    t7 = sel_target(7);
    t6 = sel_target(6);
    check(cur7 == m7_cur, "R1 R2 R4 R5 R8 w7 code", cur7, m7_cur);
    check(busy7 == (m7_cur != t7), "R7 w7 busy", busy7, m7_cur != t7);
    check(mask7 == (m7_cur != t7), "R7 w7 mask", mask7, m7_cur != t7);
    check(flag7 == (oc_raw && m7_cur == t7), "R7 w7 flag", flag7, oc_raw && m7_cur == t7);
    check(coarse7 == t7[6], "R5 coarse", coarse7, t7[6]);
    check({1'b0, cur6} == m6_cur, "R1 R2 R4 R6 R8 w6 code", cur6, m6_cur);
    check(busy6 == (m6_cur != t6), "R7 w6 busy", busy6, m6_cur != t6);
    check(flag6 == (oc_raw && m6_cur == t6), "R7 w6 flag", flag6, oc_raw && m6_cur == t6);
    check(coarse6 == 1'b0, "R6 coarse low", coarse6, 0);
  end

  always @(negedge clk) begin
    tick_us = tick_en ? ($urandom % 2 == 0) : 1'b0;
    oc_raw  = ($urandom % 4 == 0);
  end

  task automatic wait_idle();
    int guard = 0;
    do begin
      @(negedge clk);
      guard++;
    end while ((busy7 || busy6) && guard < 20000);
  endtask

  // Measures ticks from a target change to the first step in both widths.
  task automatic measure(input logic [6:0] from_c, input logic [6:0] to_c,
                         input int exp7, input int exp6, input string tag);
    int n7 = 0, n6 = 0;
    bit d7 = 0, d6 = 0;
    logic [6:0] s7;
    logic [5:0] s6;
    run_code = from_c;
    standby = 1'b0;
    wait_idle();
    s7 = cur7; s6 = cur6;
    run_code = to_c;
    @(posedge clk);  // restart edge, its tick is discarded (R8)
    for (int i = 0; i < 2000 && !(d7 && d6); i++) begin
      @(posedge clk);
      if (tick_us && !d7) n7++;
      if (tick_us && !d6) n6++;
      #1;
      if (cur7 != s7) d7 = 1;
      if (cur6 != s6) d6 = 1;
    end
    check(n7 == exp7, {tag, " w7 first step ticks"}, n7, exp7);
    check(n6 == exp6, {tag, " w6 first step ticks"}, n6, exp6);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(cur7 == 0 && !busy7 && !mask7, "R3 reset state", cur7, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R3: default speed gives 4 ticks
    measure(7'd10, 7'd12, 4, 4, "R3 default speed");
    for (int s = 0; s < 4; s++) begin
      @(negedge clk);
      speed_in = 2'(s); speed_we = 1'b1;
      @(negedge clk);
      speed_we = 1'b0;
      measure(7'd10, 7'd12, 2 << s, 2 << s, "R2 speed");
      // R5 coarse doubling in w7, R6 none in w6 (targets 70/72 -> 6/8)
      measure(7'd70, 7'd72, 4 << s, 2 << s, "R5 R6 coarse");
    end
    wait_idle();
    // R1: standby selects the standby code
    stby_code = 7'd20; standby = 1'b1;
    wait_idle();
    check(cur7 == 20, "R1 standby target", cur7, 20);
    standby = 1'b0;
    wait_idle();
    check(cur7 == run_code, "R1 run target", cur7, run_code);
    // R9: no tick, no movement
    tick_en = 1'b0;
    run_code = 7'd5;
    repeat (60) @(negedge clk);
    check(cur7 == 72 && busy7, "R9 no step without tick", cur7, 72);
    tick_en = 1'b1;
    // Random phase with mid-ramp retargets (R8)
    for (int k = 0; k < 120; k++) begin
      int r;
      r = $urandom % 5;
      if (r == 0) standby = ~standby;
      else if (r == 1) run_code = 7'($urandom);
      else if (r == 2) stby_code = 7'($urandom % 24) + run_code;
      else if (r == 3) begin speed_in = 2'($urandom); speed_we = 1'b1; end
      else run_code = cur7 + 7'd3;
      @(negedge clk);
      speed_we = 1'b0;
      repeat ($urandom % 300) @(negedge clk);
    end
    wait_idle();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1200000;
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule